// File: doc/BRIEF.md
# SPI Register-Access Frontend for a Dual-Channel UART

This block is the serial host port of a two-channel UART register file. An SPI master opens a frame by pulling chip select low and sends a command byte. The command names the direction, one of sixteen register addresses and the target channel. One or more data bytes follow. The frontend turns each complete byte into a single-cycle strobe on a simple register bus. That bus has a shared address, write data and write-bit mask, per-channel write and read strobes, and a per-channel read-data input. For reads, the fetched byte is shifted back on the serial output.

The frontend also holds the access rules that belong to the port and not to the registers:
- A clear of the modem or GPIO interrupt is pulsed when the matching status register is read.
- A write-bit mask keeps the enhanced bits of the interrupt-enable and modem-control registers fixed unless that channel's enhanced-features enable is set.
- A per-channel divisor-select input remaps address 1 away from the interrupt-enable register, which lifts its protection.
- Channel codes with no channel behind them are dropped.

The SPI pins are sampled by the system clock through synchronizers, so the system clock must be several times faster than SCLK.

Top module: `spi_uart_regif`

## Requirements
- R1: The first byte after chip select falls is the command, received MSB first on rising SCLK edges. Bit 7 is the direction (1 = read), bits 6:3 are the register address, bits 2:1 are the channel (00 = channel A on index 0, 01 = channel B on index 1), and bit 0 is ignored.
- R2: After a write command, every complete data byte gives one `reg_wr` pulse on the addressed channel, with `reg_addr` and `reg_wdata` equal to the address and the byte. Later bytes in the same frame go to the same address.
- R3: After a read command, one `reg_rd` pulse is issued at the end of the command byte and one at the end of each data byte while chip select stays low. The byte sampled from that channel's `reg_rdata` is shifted out MSB first on `spi_so`, and a new bit appears after each falling SCLK edge.
- R4: While a channel's `enh_en` is low, a write to address 1 carries `reg_wmask` 0x0F (bits 7:4 locked), and a write to address 4 carries 0x1B (bits 7:5 and 2 locked). In every other case the mask is 0xFF.
- R5: While a channel's `div_sel` is high, address 1 is not protected: its writes carry mask 0xFF.
- R6: A read of address 6 pulses `clr_modem_irq` of that channel, and a read of address 0xB pulses `clr_gpio_irq`. Each pulse comes in the same cycle as its `reg_rd` pulse. Writes never pulse either clear.
- R7: Channel codes 10 and 11 are ignored. No write, read or clear strobe is produced, and read data on `spi_so` is 0x00.
- R8: While chip select is high, `spi_so_oe` is low and `spi_so` is 0. If chip select rises in mid-byte, the partial byte is discarded with no strobe, and the next frame starts again with a command byte.
- R9: After reset, all strobes are low and `spi_so_oe` is low.
- R10: Strobes last one cycle, and at most one channel sees a write or read strobe in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock (idle low) |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_si | input | 1 | Serial data in |
| spi_so | output | 1 | Serial data out |
| spi_so_oe | output | 1 | Output enable for `spi_so` (drive when high) |
| reg_addr | output | 4 | Register address of the current access |
| reg_wdata | output | 8 | Write data |
| reg_wmask | output | 8 | Bits of `reg_wdata` that may be modified |
| reg_wr | output | NCH | Per-channel write strobe |
| reg_rd | output | NCH | Per-channel read strobe |
| reg_rdata | input | NCH*8 | Per-channel read data, channel i at bits 8i+7:8i |
| enh_en | input | NCH | Per-channel enhanced-features enable |
| div_sel | input | NCH | Per-channel divisor-register set selected |
| clr_modem_irq | output | NCH | Per-channel modem-interrupt clear pulse |
| clr_gpio_irq | output | NCH | Per-channel GPIO-interrupt clear pulse |

## Verification
The hardest state to reach is a chip-select rise partway through a data byte, after a complete command byte has already armed a write. The command alone leaves no trace at the ports, so a wrongly kept bit count or shift register only shows up in the next frame. The stimulus sends a write command plus four data bits and then releases chip select. It also aborts a frame during the command byte. A full frame follows, and its strobes and data must match a fresh decode. The burst read relies on a read-data model that advances on every read strobe, so a missing or extra prefetch shifts every later expected byte.

// File: rtl/spi_regif_pkg.sv
package spi_regif_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 4;
    localparam int CHF_W  = 2;

    // register addresses with port-level side effects or protection
    localparam logic [ADDR_W-1:0] ADDR_IER  = 4'h1;
    localparam logic [ADDR_W-1:0] ADDR_MCR  = 4'h4;
    localparam logic [ADDR_W-1:0] ADDR_MSR  = 4'h6;
    localparam logic [ADDR_W-1:0] ADDR_GPIO = 4'hB;

    // bits writable while enhanced features are disabled
    localparam logic [DATA_W-1:0] IER_OPEN_BITS = 8'h0F;
    localparam logic [DATA_W-1:0] MCR_OPEN_BITS = 8'h1B;

    typedef enum logic {
        PH_CMD  = 1'b0,
        PH_DATA = 1'b1
    } phase_e;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int              W       = 3,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] pipe;
        logic [W-1:0]             last;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d         = sync_q;
        sync_d.pipe[0] = pin_i;
        for (int s = 1; s < STAGES; s++) begin
            sync_d.pipe[s] = sync_q.pipe[s-1];
        end
        sync_d.last = sync_q.pipe[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= {(STAGES+1){RST_VAL}};
        else        sync_q <= sync_d;
    end

    assign lvl_o = sync_q.pipe[STAGES-1];

    // per-pin edge detectors
    for (genvar b = 0; b < W; b++) begin : g_edge
        assign rise_o[b] =  lvl_o[b] & ~sync_q.last[b];
        assign fall_o[b] = ~lvl_o[b] &  sync_q.last[b];
    end

endmodule

// File: rtl/spi_rx_shift.sv
module spi_rx_shift #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          sample_i,
    input  logic          bit_i,
    output logic          done_o,
    output logic [DW-1:0] byte_o
);

    localparam int CW = $clog2(DW);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [DW-2:0] sh;
    } rx_t;

    rx_t rx_d, rx_q;

    always_comb begin
        rx_d   = rx_q;
        done_o = 1'b0;
        byte_o = {rx_q.sh, bit_i};
        if (clear_i) begin
            rx_d = '0;
        end else if (sample_i) begin
            rx_d.sh = {rx_q.sh[DW-3:0], bit_i};
            if (rx_q.cnt == CW'(DW-1)) begin
                done_o     = 1'b1;
                rx_d.cnt   = '0;
            end else begin
                rx_d.cnt = rx_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_q <= '0;
        else        rx_q <= rx_d;
    end

endmodule

// File: rtl/spi_wmask.sv
module spi_wmask
    import spi_regif_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              enh_i,
    input  logic              div_i,
    output logic [DATA_W-1:0] mask_o
);

    always_comb begin
        mask_o = '1;
        if (!enh_i) begin
            unique case (addr_i)
                ADDR_IER: if (!div_i) mask_o = IER_OPEN_BITS;
                ADDR_MCR: mask_o = MCR_OPEN_BITS;
                default:  mask_o = '1;
            endcase
        end
    end

endmodule

// File: rtl/spi_uart_regif.sv
module spi_uart_regif
    import spi_regif_pkg::*;
#(
    parameter int NCH         = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_si,
    output logic              spi_so,
    output logic              spi_so_oe,
    output logic [3:0]        reg_addr,
    output logic [7:0]        reg_wdata,
    output logic [7:0]        reg_wmask,
    output logic [NCH-1:0]    reg_wr,
    output logic [NCH-1:0]    reg_rd,
    input  logic [NCH*8-1:0]  reg_rdata,
    input  logic [NCH-1:0]    enh_en,
    input  logic [NCH-1:0]    div_sel,
    output logic [NCH-1:0]    clr_modem_irq,
    output logic [NCH-1:0]    clr_gpio_irq
);

    localparam int PIN_SCLK = 0;
    localparam int PIN_CS   = 1;
    localparam int PIN_SI   = 2;
    localparam int NPIN     = 3;
    localparam logic [NPIN-1:0] PIN_RST = 3'b010;

    // ---------------- pin synchronisation ----------------
    logic [NPIN-1:0] pin_lvl, pin_rise, pin_fall;

    spi_pin_sync #(
        .W       (NPIN),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_RST)
    ) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  ({spi_si, spi_cs_n, spi_sclk}),
        .lvl_o  (pin_lvl),
        .rise_o (pin_rise),
        .fall_o (pin_fall)
    );

    logic cs_act, sclk_rise, sclk_fall;
    assign cs_act    = ~pin_lvl[PIN_CS];
    assign sclk_rise = pin_rise[PIN_SCLK];
    assign sclk_fall = pin_fall[PIN_SCLK];

    // ---------------- byte assembly ----------------
    logic             byte_done;
    logic [DATA_W-1:0] rx_byte;

    spi_rx_shift #(.DW(DATA_W)) i_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (~cs_act),
        .sample_i (sclk_rise),
        .bit_i    (pin_lvl[PIN_SI]),
        .done_o   (byte_done),
        .byte_o   (rx_byte)
    );

    // ---------------- frame state ----------------
    typedef struct packed {
        phase_e             phase;
        logic               is_rd;
        logic [ADDR_W-1:0]  addr;
        logic [CHF_W-1:0]   ch;
        logic [NCH-1:0]     wr;
        logic [NCH-1:0]     rd;
        logic [NCH-1:0]     clrm;
        logic [NCH-1:0]     clrg;
        logic [DATA_W-1:0]  wdata;
        logic [DATA_W-1:0]  wmask;
        logic [DATA_W-1:0]  tx;
        logic               so_bit;
    } fe_t;

    fe_t fe_d, fe_q;

    // per-channel selections for the latched channel field
    logic [DATA_W-1:0] rd_sel;
    logic              enh_s, div_s;

    always_comb begin
        rd_sel = '0;
        enh_s  = 1'b0;
        div_s  = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            if (fe_q.ch == CHF_W'(i)) begin
                rd_sel = reg_rdata[i*DATA_W +: DATA_W];
                enh_s  = enh_en[i];
                div_s  = div_sel[i];
            end
        end
    end

    logic [DATA_W-1:0] wmask_w;

    spi_wmask i_wmask (
        .addr_i (fe_q.addr),
        .enh_i  (enh_s),
        .div_i  (div_s),
        .mask_o (wmask_w)
    );

    // access target: fresh command fields or the latched ones
    logic [ADDR_W-1:0] acc_addr;
    logic [CHF_W-1:0]  acc_ch;
    logic [NCH-1:0]    acc_oh;

    always_comb begin
        acc_addr = (fe_q.phase == PH_CMD) ? rx_byte[6:3] : fe_q.addr;
        acc_ch   = (fe_q.phase == PH_CMD) ? rx_byte[2:1] : fe_q.ch;
        acc_oh   = '0;
        for (int i = 0; i < NCH; i++) begin
            acc_oh[i] = (acc_ch == CHF_W'(i));
        end
    end

    always_comb begin
        fe_d      = fe_q;
        fe_d.wr   = '0;
        fe_d.rd   = '0;
        fe_d.clrm = '0;
        fe_d.clrg = '0;
        if (!cs_act) begin
            fe_d.phase  = PH_CMD;
            fe_d.tx     = '0;
            fe_d.so_bit = 1'b0;
        end else begin
            // fetched byte lands one cycle after the read strobe
            if (|fe_q.rd) fe_d.tx = rd_sel;
            if (byte_done) begin
                if (fe_q.phase == PH_CMD) begin
                    fe_d.phase = PH_DATA;
                    fe_d.is_rd = rx_byte[7];
                    fe_d.addr  = rx_byte[6:3];
                    fe_d.ch    = rx_byte[2:1];
                end
                if ((fe_q.phase == PH_CMD) ? rx_byte[7] : fe_q.is_rd) begin
                    fe_d.rd   = acc_oh;
                    fe_d.clrm = (acc_addr == ADDR_MSR)  ? acc_oh : '0;
                    fe_d.clrg = (acc_addr == ADDR_GPIO) ? acc_oh : '0;
                end else if (fe_q.phase == PH_DATA) begin
                    fe_d.wr    = acc_oh;
                    fe_d.wdata = rx_byte;
                    fe_d.wmask = wmask_w;
                end
            end
            if (sclk_fall) begin
                fe_d.so_bit = fe_d.tx[DATA_W-1];
                fe_d.tx     = {fe_d.tx[DATA_W-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fe_q       <= '0;
            fe_q.phase <= PH_CMD;
        end else begin
            fe_q <= fe_d;
        end
    end

    assign spi_so_oe     = cs_act;
    assign spi_so        = cs_act & fe_q.so_bit;
    assign reg_addr      = fe_q.addr;
    assign reg_wdata     = fe_q.wdata;
    assign reg_wmask     = fe_q.wmask;
    assign reg_wr        = fe_q.wr;
    assign reg_rd        = fe_q.rd;
    assign clr_modem_irq = fe_q.clrm;
    assign clr_gpio_irq  = fe_q.clrg;

endmodule

// File: rtl/spi_uart_regif_chk.sv
module spi_uart_regif_chk
    import spi_regif_pkg::*;
#(
    parameter int NCH = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             spi_so,
    input logic             spi_so_oe,
    input logic [3:0]       reg_addr,
    input logic [7:0]       reg_wmask,
    input logic [NCH-1:0]   reg_wr,
    input logic [NCH-1:0]   reg_rd,
    input logic [NCH-1:0]   enh_en,
    input logic [NCH-1:0]   div_sel,
    input logic [NCH-1:0]   clr_modem_irq,
    input logic [NCH-1:0]   clr_gpio_irq
);

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_wr, reg_rd})); // R10

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (|{reg_wr, reg_rd}) |=> !(|{reg_wr, reg_rd})); // R10

    AST_MODEM_CLR_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_modem_irq) |-> (clr_modem_irq == reg_rd) && (reg_addr == ADDR_MSR)); // R6

    AST_GPIO_CLR_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_gpio_irq) |-> (clr_gpio_irq == reg_rd) && (reg_addr == ADDR_GPIO)); // R6

    AST_SO_QUIET_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_so_oe) |-> !spi_so); // R8

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        AST_IER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr[i] && reg_addr == ADDR_IER && !$past(enh_en[i]) && !$past(div_sel[i]))
            |-> reg_wmask == IER_OPEN_BITS); // R4

        AST_MCR_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr[i] && reg_addr == ADDR_MCR && !$past(enh_en[i]))
            |-> reg_wmask == MCR_OPEN_BITS); // R4

        AST_DIV_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr[i] && reg_addr == ADDR_IER && $past(div_sel[i]))
            |-> reg_wmask == 8'hFF); // R5
    end

endmodule

bind spi_uart_regif spi_uart_regif_chk #(.NCH(NCH)) i_chk (.*);

// File: tb/test_spi_uart_regif.sv
module test_spi_uart_regif;

    localparam int NCH  = 2;
    localparam int HALF = 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic              rst_n;
    logic              spi_sclk, spi_cs_n, spi_si;
    logic              spi_so, spi_so_oe;
    logic [3:0]        reg_addr;
    logic [7:0]        reg_wdata, reg_wmask;
    logic [NCH-1:0]    reg_wr, reg_rd;
    logic [NCH*8-1:0]  reg_rdata;
    logic [NCH-1:0]    enh_en, div_sel;
    logic [NCH-1:0]    clr_modem_irq, clr_gpio_irq;

    spi_uart_regif #(.NCH(NCH)) i_spi_uart_regif (.*);

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- register file model ----------------
    logic [7:0] pop_cnt [NCH];
    int         exp_pop [NCH];

    function automatic logic [7:0] model(input int ch, input logic [3:0] a, input logic [7:0] p);
        return (8'(ch) * 8'h50) ^ {a, 4'h0} ^ p;
    endfunction

    always_comb begin
        for (int i = 0; i < NCH; i++) reg_rdata[i*8 +: 8] = model(i, reg_addr, pop_cnt[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) pop_cnt[i] <= '0;
        end else begin
            for (int i = 0; i < NCH; i++) if (reg_rd[i]) pop_cnt[i] <= pop_cnt[i] + 8'd1;
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        bit         is_wr;
        int         ch;
        logic [3:0] addr;
        logic [7:0] data;
        logic [7:0] mask;
        bit         clrm;
        bit         clrg;
        string      req;
    } item_t;

    item_t sb_q[$];

    always @(negedge clk) begin
        if (rst_n && (|reg_wr || |reg_rd || |clr_modem_irq || |clr_gpio_irq)) begin
            int          och = 0;
            logic [63:0] act, exp;
            item_t       e;
            for (int i = 0; i < NCH; i++) if (reg_wr[i] | reg_rd[i]) och = i;
            act = {|reg_wr, 2'(och), reg_addr,
                   (|reg_wr) ? reg_wdata : 8'h00, (|reg_wr) ? reg_wmask : 8'h00,
                   4'(clr_modem_irq), 4'(clr_gpio_irq), 4'(reg_wr | reg_rd)};
            if (sb_q.size() == 0) begin
                check(0, "R7", "unexpected strobe", act, 0);
            end else begin
                e   = sb_q.pop_front();
                exp = {e.is_wr, 2'(e.ch), e.addr,
                       e.is_wr ? e.data : 8'h00, e.is_wr ? e.mask : 8'h00,
                       4'(e.clrm ? (1 << e.ch) : 0), 4'(e.clrg ? (1 << e.ch) : 0),
                       4'(1 << e.ch)};
                check(act == exp, e.req, "strobe", act, exp);
            end
        end
    end

    // ---------------- SPI master ----------------
    logic [7:0] tx_buf [8];
    logic [7:0] rx_buf [8];

    function automatic logic [7:0] mk_cmd(input bit rd, input logic [3:0] a, input logic [1:0] ch);
        return {rd, a, ch, 1'b0};
    endfunction

    function automatic logic [7:0] exp_mask(input logic [3:0] a, input bit enh, input bit dv);
        if (enh) return 8'hFF;
        if (a == 4'h1 && !dv) return 8'h0F;
        if (a == 4'h4) return 8'h1B;
        return 8'hFF;
    endfunction

    task automatic sbit(input logic b, output logic so_s);
        spi_si = b;
        repeat (HALF) @(negedge clk);
        so_s = spi_so;
        spi_sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        spi_sclk = 1'b0;
    endtask

    task automatic sbyte(input logic [7:0] b, output logic [7:0] r);
        logic s;
        for (int k = 7; k >= 0; k--) begin
            sbit(b[k], s);
            r[k] = s;
        end
    endtask

    // full frame with expectations pushed to the scoreboard
    task automatic frame(input logic [7:0] cmd, input int n, input string req);
        bit         rd    = cmd[7];
        int         ch    = int'(cmd[2:1]);
        logic [3:0] a     = cmd[6:3];
        bit         valid = (ch < NCH);
        logic [7:0] exp_rx [8];
        logic [7:0] junk;
        item_t      it;
        for (int k = 0; k < n; k++) exp_rx[k] = 8'h00;
        if (valid) begin
            if (rd) begin
                for (int k = 0; k <= n; k++) begin
                    it = '{0, ch, a, 0, 0, a == 4'h6, a == 4'hB, req};
                    sb_q.push_back(it);
                    if (k < n) exp_rx[k] = model(ch, a, 8'(exp_pop[ch] + k));
                end
                exp_pop[ch] += n + 1;
            end else begin
                for (int k = 0; k < n; k++) begin
                    it = '{1, ch, a, tx_buf[k], exp_mask(a, enh_en[ch], div_sel[ch]), 0, 0, req};
                    sb_q.push_back(it);
                end
            end
        end
        spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        sbyte(cmd, junk);
        for (int k = 0; k < n; k++) sbyte(tx_buf[k], rx_buf[k]);
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (4 * HALF) @(negedge clk);
        if (rd) begin
            for (int k = 0; k < n; k++)
                check(rx_buf[k] === exp_rx[k], valid ? req : "R7", "SO byte", rx_buf[k], exp_rx[k]);
        end
        check(sb_q.size() == 0, req, "pending strobes", sb_q.size(), 0);
    endtask

    // aborted frame: nbits bits then chip select rises
    task automatic partial(input logic [7:0] cmd, input int nbits);
        logic s;
        spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int k = 0; k < nbits; k++) begin
            if (k < 8) sbit(cmd[7-k], s);
            else       sbit(1'b1, s);
        end
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (4 * HALF) @(negedge clk);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        for (int i = 0; i < NCH; i++) exp_pop[i] = 0;
        rst_n = 1'b0; spi_sclk = 1'b0; spi_cs_n = 1'b1; spi_si = 1'b0;
        enh_en = '0; div_sel = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R9 reset state
        check(reg_wr == '0 && reg_rd == '0, "R9", "strobes after reset", {reg_wr, reg_rd}, 0);
        check(spi_so_oe == 1'b0, "R9", "so_oe after reset", spi_so_oe, 0);
        check(clr_modem_irq == '0 && clr_gpio_irq == '0, "R9", "clears after reset",
              {clr_modem_irq, clr_gpio_irq}, 0);

        // R2 write burst to channel A
        tx_buf[0] = 8'hA5; tx_buf[1] = 8'h3C; tx_buf[2] = 8'hFF;
        frame(mk_cmd(0, 4'h2, 2'b00), 3, "R2");

        // R4 protected interrupt-enable write, channel B locked then open
        tx_buf[0] = 8'hF3;
        frame(mk_cmd(0, 4'h1, 2'b01), 1, "R4");
        enh_en[1] = 1'b1;
        frame(mk_cmd(0, 4'h1, 2'b01), 1, "R4");
        enh_en[1] = 1'b0;

        // R4 protected modem-control write on channel A
        tx_buf[0] = 8'hE4;
        frame(mk_cmd(0, 4'h4, 2'b00), 1, "R4");

        // R5 divisor set lifts protection at address 1
        div_sel[1] = 1'b1;
        tx_buf[0] = 8'h81;
        frame(mk_cmd(0, 4'h1, 2'b01), 1, "R5");
        div_sel[1] = 1'b0;

        // R3 read burst with prefetch on channel A
        frame(mk_cmd(1, 4'h0, 2'b00), 3, "R3");

        // R6 read side effects
        frame(mk_cmd(1, 4'h6, 2'b01), 1, "R6");
        frame(mk_cmd(1, 4'hB, 2'b00), 2, "R6");
        tx_buf[0] = 8'h11;
        frame(mk_cmd(0, 4'h6, 2'b01), 1, "R6");

        // R1 command bit 0 ignored
        frame(mk_cmd(1, 4'h5, 2'b01) | 8'h01, 2, "R1");

        // R7 unused channel codes
        tx_buf[0] = 8'h5A; tx_buf[1] = 8'hC3;
        frame(mk_cmd(0, 4'h3, 2'b10), 2, "R7");
        frame(mk_cmd(1, 4'h3, 2'b11), 2, "R7");

        // R8 chip select idle state
        check(spi_so_oe == 1'b0 && spi_so == 1'b0, "R8", "pins while deselected",
              {spi_so_oe, spi_so}, 0);

        // R8 aborted mid data byte and mid command byte
        partial(mk_cmd(0, 4'h7, 2'b00), 12);
        partial(mk_cmd(1, 4'h6, 2'b01), 3);
        check(sb_q.size() == 0, "R8", "no strobe from partial bytes", sb_q.size(), 0);
        tx_buf[0] = 8'h69;
        frame(mk_cmd(0, 4'h7, 2'b01), 1, "R8");
        frame(mk_cmd(1, 4'h2, 2'b01), 1, "R8");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule